// File: doc/BRIEF.md
# CAN Transmit Request Tracker

This block holds two flags for each of a small set of outgoing message slots. The first flag is a send-request bit. The second is an unsent-data bit. The block offers one pending slot at a time to a CAN protocol engine, and it updates the flags when the engine reports that a frame has started, has completed, or has failed.

The CPU writes both flags of one slot in a single cycle. The engine sees an offer: a valid bit and a slot index. The engine answers with three strobes: start, done and fail. A fail covers both lost arbitration and a bus error.

A mode input, `no_retry_i`, selects single-shot operation. In single-shot operation the send-request bit is dropped as soon as the frame starts. A failed frame then leaves the slot parked, and it is not sent again until the CPU sets the request bit again. With the mode off, a failed slot keeps both flags and is offered again.

Top module: `can_txq_tracker`

## Requirements
- R1: While reset is held and after it is released, every send-request and unsent-data flag is 0, `busy_o` is 0 and `offer_valid_o` is 0.
- R2: A CPU write (`cpu_we_i`=1) loads `cpu_rqst_i` and `cpu_pend_i` into the two flags of slot `cpu_idx_i`. The new values are visible on `rqst_o`/`pend_o` in the next cycle.
- R3: While idle, `offer_valid_o` is 1 exactly when at least one send-request flag is 1. `offer_idx_o` is then the lowest such slot index.
- R4: A start strobe is accepted only while idle with a valid offer. From then until a done or fail strobe, `busy_o`=1, `offer_valid_o`=1 and `offer_idx_o` hold the started slot, even if that slot's flags change.
- R5: With `no_retry_i`=1 at an accepted start, the started slot's send-request flag is cleared in the next cycle and its unsent-data flag is unchanged.
- R6: A done strobe while busy clears the slot's unsent-data flag. If the transfer began with `no_retry_i`=0, it also clears the send-request flag. The block then returns to idle.
- R7: With `no_retry_i`=0 at start, a fail strobe while busy leaves both flags unchanged and returns to idle, so the same slot is offered again.
- R8: With `no_retry_i`=1 at start, a failed slot keeps unsent-data=1 and send-request=0. It is not offered again until the CPU writes its send-request flag to 1.
- R9: When a CPU write and an accepted start or done hit the same slot in the same cycle, that slot's flags take the CPU-written values.
- R10: A start while busy, or a done or fail while idle, changes no flag and no offer. If done and fail arrive together while busy, they are treated as done.
- R11: The retry mode that governs a transfer is the value of `no_retry_i` captured at its accepted start. Later changes of the input do not affect that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released on the clock |
| no_retry_i | input | 1 | 1 = single-shot mode, automatic retransmission off |
| cpu_we_i | input | 1 | CPU flag write strobe |
| cpu_idx_i | input | $clog2(NBUF) | Slot written by the CPU |
| cpu_rqst_i | input | 1 | Send-request value to write |
| cpu_pend_i | input | 1 | Unsent-data value to write |
| tx_start_i | input | 1 | Engine has started sending the offered slot |
| tx_done_i | input | 1 | Engine finished the frame successfully |
| tx_fail_i | input | 1 | Engine lost arbitration or hit an error |
| offer_valid_o | output | 1 | A slot is offered or in flight |
| offer_idx_o | output | $clog2(NBUF) | Offered or in-flight slot index |
| busy_o | output | 1 | A transfer is in flight |
| rqst_o | output | NBUF | Send-request flags, bit i = slot i |
| pend_o | output | NBUF | Unsent-data flags, bit i = slot i |

## Verification
The bench uses the default of eight slots. With eight slots, the top index 7 can be reached, and the lowest-first choice can be checked with requests spread across the whole vector. Directed phases cover single-shot parking and re-arming, automatic retry, the same-cycle CPU-versus-engine collision, stray strobes, and a mode flip during a transfer. A long mixed phase then drives biased random writes and strobes, which brings in collisions on slot 0 and slot 7 and back-to-back start/done pairs.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;

  typedef enum logic {
    TXQ_IDLE   = 1'b0,
    TXQ_FLIGHT = 1'b1
  } txq_state_e;

  // Accepted engine events, one cycle wide, for the flag array
  typedef struct packed {
    logic start;
    logic done;
    logic dar;
  } txq_evt_t;

endpackage

// File: rtl/txq_pick.sv
module txq_pick #(
  parameter int NBUF = 8,
  parameter int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic [NBUF-1:0] req_vec,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);

  // Scan from the top down so the lowest set bit is the last one written
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (req_vec[i]) begin
        any_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/txq_flight.sv
module txq_flight
  import can_txq_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            no_retry,
  input  logic            start,
  input  logic            done,
  input  logic            fail,
  input  logic            offer_any,
  input  logic [IDXW-1:0] offer_idx,
  output logic            busy_o,
  output logic [IDXW-1:0] fidx_o,
  output txq_evt_t        evt_o,
  output logic            fail_acc_o
);

  txq_state_e      st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            dar_q, dar_d;
  logic            ld_en;
  logic            acc_start, acc_done, acc_fail;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    dar_d     = dar_q;
    acc_start = 1'b0;
    acc_done  = 1'b0;
    acc_fail  = 1'b0;
    case (st_q)
      TXQ_IDLE: begin
        if (start && offer_any) begin
          st_d      = TXQ_FLIGHT;
          idx_d     = offer_idx;
          dar_d     = no_retry;
          acc_start = 1'b1;
        end
      end
      TXQ_FLIGHT: begin
        if (done) begin
          acc_done = 1'b1;
          st_d     = TXQ_IDLE;
        end else if (fail) begin
          acc_fail = 1'b1;
          st_d     = TXQ_IDLE;
        end
      end
      default: st_d = TXQ_IDLE;
    endcase
  end

  assign ld_en = acc_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TXQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      dar_q <= 1'b0;
    end else if (ld_en) begin
      idx_q <= idx_d;
      dar_q <= dar_d;
    end
  end

  assign busy_o     = (st_q == TXQ_FLIGHT);
  // Index of the event: the offer on a start, the frozen slot otherwise
  assign fidx_o     = busy_o ? idx_q : offer_idx;
  assign evt_o.start = acc_start;
  assign evt_o.done  = acc_done;
  assign evt_o.dar   = busy_o ? dar_q : no_retry;
  assign fail_acc_o  = acc_fail;

  AST_FROZEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done && !fail |=> busy_o && $stable(idx_q)) else $error("frozen slot moved");  // R4

  AST_STRAY_END_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start && (done || fail) |=> !busy_o) else $error("stray end strobe acted");  // R10

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !done && !fail |=> $stable(dar_q)) else $error("captured mode changed");  // R11

endmodule

// File: rtl/txq_flags.sv
module txq_flags
  import can_txq_pkg::*;
#(
  parameter int NBUF = 8,
  parameter int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  input  logic [IDXW-1:0] cpu_idx,
  input  logic            cpu_rqst,
  input  logic            cpu_pend,
  input  txq_evt_t        evt,
  input  logic [IDXW-1:0] evt_idx,
  output logic [NBUF-1:0] rqst_o,
  output logic [NBUF-1:0] pend_o
);

  for (genvar g = 0; g < NBUF; g++) begin : g_slot
    logic r_q, r_d, p_q, p_d;
    logic hit_cpu, hit_evt, en;

    assign hit_cpu = cpu_we && (cpu_idx == IDXW'(g));
    assign hit_evt = (evt.start || evt.done) && (evt_idx == IDXW'(g));
    assign en      = hit_cpu || hit_evt;

    always_comb begin
      r_d = r_q;
      p_d = p_q;
      if (hit_cpu) begin
        r_d = cpu_rqst;
        p_d = cpu_pend;
      end else if (hit_evt) begin
        if (evt.start && evt.dar) begin
          r_d = 1'b0;
        end
        if (evt.done) begin
          p_d = 1'b0;
          if (!evt.dar) begin
            r_d = 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_q <= 1'b0;
        p_q <= 1'b0;
      end else if (en) begin
        r_q <= r_d;
        p_q <= p_d;
      end
    end

    assign rqst_o[g] = r_q;
    assign pend_o[g] = p_q;
  end

  AST_CPU_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we |=> rqst_o[$past(cpu_idx)] == $past(cpu_rqst)
            && pend_o[$past(cpu_idx)] == $past(cpu_pend)) else $error("cpu write lost");  // R2

  AST_CPU_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && (evt.start || evt.done) && cpu_idx == evt_idx
      |=> rqst_o[$past(evt_idx)] == $past(cpu_rqst)) else $error("event beat cpu");  // R9

  AST_START_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start && evt.dar && !(cpu_we && cpu_idx == evt_idx)
      |=> !rqst_o[$past(evt_idx)] && pend_o[$past(evt_idx)] == $past(pend_o[evt_idx]))
    else $error("single-shot start flags wrong");  // R5

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.done && !(cpu_we && cpu_idx == evt_idx) |=> !pend_o[$past(evt_idx)])
    else $error("done left data flag");  // R6

endmodule

// File: rtl/can_txq_tracker.sv
module can_txq_tracker
  import can_txq_pkg::*;
#(
  parameter int NBUF = 8,
  localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            no_retry_i,
  input  logic            cpu_we_i,
  input  logic [IDXW-1:0] cpu_idx_i,
  input  logic            cpu_rqst_i,
  input  logic            cpu_pend_i,
  input  logic            tx_start_i,
  input  logic            tx_done_i,
  input  logic            tx_fail_i,
  output logic            offer_valid_o,
  output logic [IDXW-1:0] offer_idx_o,
  output logic            busy_o,
  output logic [NBUF-1:0] rqst_o,
  output logic [NBUF-1:0] pend_o
);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  logic            pick_any;
  logic [IDXW-1:0] pick_idx;
  logic [IDXW-1:0] fidx;
  txq_evt_t        evt;
  logic            fail_acc;

  txq_pick #(.NBUF(NBUF), .IDXW(IDXW)) u_pick (
    .req_vec (rqst_o),
    .any_o   (pick_any),
    .idx_o   (pick_idx)
  );

  txq_flight #(.NBUF(NBUF), .IDXW(IDXW)) u_flight (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .no_retry   (no_retry_i),
    .start      (tx_start_i),
    .done       (tx_done_i),
    .fail       (tx_fail_i),
    .offer_any  (pick_any),
    .offer_idx  (pick_idx),
    .busy_o     (busy_o),
    .fidx_o     (fidx),
    .evt_o      (evt),
    .fail_acc_o (fail_acc)
  );

  txq_flags #(.NBUF(NBUF), .IDXW(IDXW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cpu_we   (cpu_we_i),
    .cpu_idx  (cpu_idx_i),
    .cpu_rqst (cpu_rqst_i),
    .cpu_pend (cpu_pend_i),
    .evt      (evt),
    .evt_idx  (fidx),
    .rqst_o   (rqst_o),
    .pend_o   (pend_o)
  );

  assign offer_valid_o = busy_o || pick_any;
  assign offer_idx_o   = fidx;

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_int_n)
    offer_valid_o && !busy_o |-> rqst_o[offer_idx_o]
      && ((rqst_o & ((NBUF'(1) << offer_idx_o) - NBUF'(1))) == '0))
    else $error("offer not lowest");  // R3

  AST_BUSY_OFFERS: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy_o |-> offer_valid_o) else $error("busy without offer");  // R4

  AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    fail_acc && !cpu_we_i |=> $stable(rqst_o) && $stable(pend_o))
    else $error("fail changed flags");  // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_int_n |-> rqst_o == '0 && pend_o == '0 && !busy_o) else $error("reset state");  // R1

endmodule

// File: tb/can_txq_tracker_tb.sv
module can_txq_tracker_tb;

  localparam int NB = 8;
  localparam int IW = 3;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          no_retry, cpu_we, cpu_rqst, cpu_pend;
  logic [IW-1:0] cpu_idx;
  logic          tx_start, tx_done, tx_fail;
  logic          offer_valid, busy;
  logic [IW-1:0] offer_idx;
  logic [NB-1:0] rqst, pend;

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [NB-1:0] m_rq, m_pd;
  bit            m_busy, m_fdar;
  int            m_fidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_txq_tracker #(.NBUF(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .no_retry_i(no_retry),
    .cpu_we_i(cpu_we), .cpu_idx_i(cpu_idx), .cpu_rqst_i(cpu_rqst), .cpu_pend_i(cpu_pend),
    .tx_start_i(tx_start), .tx_done_i(tx_done), .tx_fail_i(tx_fail),
    .offer_valid_o(offer_valid), .offer_idx_o(offer_idx), .busy_o(busy),
    .rqst_o(rqst), .pend_o(pend)
  );

  function automatic int model_offer();
    if (m_busy) return m_fidx;
    for (int i = 0; i < NB; i++) if (m_rq[i]) return i;
    return -1;
  endfunction

  task automatic compare(input string tag);
    int eo = model_offer();
    vectors++;
    if (busy !== m_busy || offer_valid !== (eo >= 0) || rqst !== m_rq || pend !== m_pd ||
        (eo >= 0 && int'(offer_idx) != eo)) begin
      misses++;
      $display("FAIL %s: busy=%0b valid=%0b idx=%0d rqst=%b pend=%b expected busy=%0b valid=%0b idx=%0d rqst=%b pend=%b",
               tag, busy, offer_valid, offer_idx, rqst, pend,
               m_busy, eo >= 0, eo, m_rq, m_pd);
    end
  endtask

  task automatic idle_inputs();
    cpu_we = 0; cpu_idx = '0; cpu_rqst = 0; cpu_pend = 0;
    tx_start = 0; tx_done = 0; tx_fail = 0;
  endtask

  // Inputs are set at the negedge before the call
  task automatic cyc(input string tag);
    logic [NB-1:0] n_rq = m_rq, n_pd = m_pd;
    bit nb = m_busy, nd = m_fdar;
    int nf = m_fidx;
    int eo = model_offer();
    if (m_busy && tx_done) begin
      n_pd[m_fidx] = 1'b0;
      if (!m_fdar) n_rq[m_fidx] = 1'b0;
      nb = 0;
    end else if (m_busy && tx_fail) begin
      nb = 0;
    end else if (!m_busy && tx_start && eo >= 0) begin
      nb = 1; nf = eo; nd = no_retry;
      if (no_retry) n_rq[eo] = 1'b0;
    end
    if (cpu_we) begin
      n_rq[cpu_idx] = cpu_rqst;
      n_pd[cpu_idx] = cpu_pend;
    end
    @(posedge clk);
    m_rq = n_rq; m_pd = n_pd; m_busy = nb; m_fidx = nf; m_fdar = nd;
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic wr(input int idx, input bit r, input bit p, input string tag);
    cpu_we = 1; cpu_idx = IW'(idx); cpu_rqst = r; cpu_pend = p;
    cyc(tag);
  endtask

  task automatic strobe(input bit s, input bit d, input bit f, input string tag);
    tx_start = s; tx_done = d; tx_fail = f;
    cyc(tag);
  endtask

  initial begin
    rst_n = 1'b1;
    no_retry = 0;
    idle_inputs();
    m_rq = '0; m_pd = '0; m_busy = 0; m_fidx = 0; m_fdar = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 held");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 released");

    // R2 / R3: writes and lowest-first offer
    wr(5, 1, 1, "R2");
    wr(3, 1, 1, "R2");
    cyc("R3 offer 3");
    wr(7, 1, 1, "R3");
    wr(0, 1, 1, "R3 offer 0");
    wr(0, 0, 0, "R3 offer back to 3");

    // R5 / R4: single-shot start parks request, offer frozen
    no_retry = 1;
    strobe(1, 0, 0, "R5");
    cyc("R4 frozen");
    wr(1, 1, 1, "R4 lower slot during flight");
    strobe(1, 0, 0, "R10 start while busy");
    // R8: fail leaves slot parked, next offer is lower slot 1
    strobe(0, 0, 1, "R8");
    strobe(1, 0, 0, "R5 slot 1");
    strobe(0, 1, 0, "R6 single-shot done");
    cyc("R8 slot 3 still parked");
    wr(3, 1, 1, "R8 rearm");

    // R7: auto retry
    no_retry = 0;
    strobe(1, 0, 0, "R7 start");
    strobe(0, 0, 1, "R7 fail");
    cyc("R7 reoffered");
    strobe(1, 0, 0, "R7 restart");
    strobe(0, 1, 0, "R6 both cleared");

    // R10: stray strobes while idle; done+fail together
    strobe(0, 1, 0, "R10 stray done");
    strobe(0, 0, 1, "R10 stray fail");
    strobe(1, 0, 0, "R10 start");
    strobe(0, 1, 1, "R10 done wins");

    // R9: collision of cpu write with start and with done
    wr(2, 1, 1, "R9 setup");
    no_retry = 1;
    tx_start = 1; cpu_we = 1; cpu_idx = 2; cpu_rqst = 1; cpu_pend = 0;
    cyc("R9 start vs cpu");
    tx_done = 1; cpu_we = 1; cpu_idx = 2; cpu_rqst = 1; cpu_pend = 1;
    cyc("R9 done vs cpu");

    // R11: mode captured at start
    no_retry = 0;
    strobe(1, 0, 0, "R11 start auto");
    no_retry = 1;
    strobe(0, 1, 0, "R11 done uses captured mode");
    no_retry = 1;
    wr(4, 1, 1, "R11 setup");
    strobe(1, 0, 0, "R11 start single");
    no_retry = 0;
    strobe(0, 0, 1, "R11 fail keeps parked");

    // Mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      no_retry = ($urandom_range(0, 3) == 0) ? ~no_retry : no_retry;
      cpu_we   = (r < 25);
      cpu_idx  = IW'($urandom_range(0, NB - 1));
      if ($urandom_range(0, 3) == 0) cpu_idx = ($urandom_range(0, 1) != 0) ? IW'(0) : IW'(NB - 1);
      cpu_rqst = ($urandom_range(0, 3) != 0);
      cpu_pend = ($urandom_range(0, 3) != 0);
      tx_start = ($urandom_range(0, 2) == 0);
      tx_done  = ($urandom_range(0, 4) == 0);
      tx_fail  = ($urandom_range(0, 5) == 0);
      cyc("mixed");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule